// File: doc/BRIEF.md
# Single-Bit Boolean Processor

This block carries out one-bit logic operations for a small controller. It holds a carry flag of its own and can also act on any bit of the bit-addressable space. That space covers a window of internal RAM plus the upper special-register area. A request gives a four-bit operation code and an eight-bit bit address, and is accepted on a `start` pulse.

Operations that touch only the carry finish at once. The others reach the byte that holds the addressed bit through a byte-wide memory port. That port reads asynchronously and writes on the clock edge. Operations that change an addressed bit read the byte, alter only that bit, and write the byte back. `done` pulses once as each operation finishes. `busy` is high while the memory port is in use.

Top module: `bitproc`

## Requirements
- R1: Op codes 0, 1 and 2 clear, set and complement the carry. They finish with `done` high in the cycle right after the accepting edge (latency 1), and the memory strobes stay low.
- R2: Op codes 3, 4 and 5 clear, set and complement the addressed bit. `done` follows three cycles after acceptance. The other seven bits of the byte are kept, and the carry does not change.
- R3: Op code 6 leaves carry AND bit in the carry, and op code 7 leaves carry AND NOT bit. Both have latency 2 and leave memory unchanged.
- R4: Op code 8 leaves carry OR bit in the carry, and op code 9 leaves carry OR NOT bit. Both have latency 2.
- R5: Op code 10 copies the addressed bit into the carry, with latency 2.
- R6: Op code 11 copies the carry into the addressed bit, with latency 3. The write strobe follows a read of the same byte address.
- R7: A bit address below 0x80 selects RAM byte 0x20 + (address >> 3). A bit address of 0x80 or above selects the special-register byte (address & 0xF8). Address bits [2:0] give the bit position in that byte.
- R8: `done` is a one-cycle pulse per operation. The carry changes only on the edge that completes an operation whose destination is the carry.
- R9: A `start` seen while `busy` is high is ignored.
- R10: After reset the carry is 0, and `done`, `busy`, `mem_rd` and `mem_wr` are all 0. The two strobes are never high together.
- R11: Op codes 12 to 15 are reserved. They finish with latency 1 and change neither the carry nor memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept a request while idle |
| op | input | 4 | Operation code |
| bit_addr | input | 8 | Bit address |
| mem_addr | output | 8 | Byte address to memory |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid during `mem_rd` |
| carry | output | 1 | Carry flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |

## Verification
Two things can land in the same cycle: a new `start` and an operation that is still in flight. The bench starts a bit write and then keeps `start` high with a carry-complement code through the read and write cycles. It drops `start` only once `done` shows. The carry must keep its old value, the byte must carry only the intended change, and `done` must pulse just once.

// File: rtl/bitproc_pkg.sv
package bitproc_pkg;

    typedef enum logic [3:0] {
        OP_CLR_C  = 4'd0,
        OP_SET_C  = 4'd1,
        OP_CPL_C  = 4'd2,
        OP_CLR_B  = 4'd3,
        OP_SET_B  = 4'd4,
        OP_CPL_B  = 4'd5,
        OP_AND_C  = 4'd6,
        OP_ANDN_C = 4'd7,
        OP_OR_C   = 4'd8,
        OP_ORN_C  = 4'd9,
        OP_LD_C   = 4'd10,
        OP_ST_C   = 4'd11,
        OP_RSV12  = 4'd12,
        OP_RSV13  = 4'd13,
        OP_RSV14  = 4'd14,
        OP_RSV15  = 4'd15
    } bp_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } bp_state_e;

    // true when no memory access is needed
    function automatic logic op_carry_only(bp_op_e o);
        return (o <= OP_CPL_C) || (o >= OP_RSV12);
    endfunction

    // true when the addressed bit is the destination
    function automatic logic op_writes_bit(bp_op_e o);
        return (o == OP_CLR_B) || (o == OP_SET_B) || (o == OP_CPL_B) || (o == OP_ST_C);
    endfunction

endpackage

// File: rtl/bitproc_addr_map.sv
module bitproc_addr_map #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int RAM_BASE = 32'h20,
    localparam int POS_W   = $clog2(DATA_W)
) (
    input  logic [ADDR_W-1:0] bit_addr,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [POS_W-1:0]  bit_pos
);
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(RAM_BASE);
    localparam logic [ADDR_W-1:0] POS_MASK = ADDR_W'(DATA_W - 1);

    always_comb begin
        bit_pos = bit_addr[POS_W-1:0];
        if (bit_addr[ADDR_W-1] == 1'b0)
            byte_addr = BASE + (bit_addr >> POS_W);
        else
            byte_addr = bit_addr & ~POS_MASK;
    end

    // R7: special-register bytes are always aligned to the byte width
    always_comb begin
        a_r7_sfr_aligned: assert (!bit_addr[ADDR_W-1] || ((byte_addr & POS_MASK) == '0));
    end
endmodule

// File: rtl/bitproc_alu.sv
module bitproc_alu
    import bitproc_pkg::*;
(
    input  bp_op_e op,
    input  logic   c_in,
    input  logic   b_in,
    output logic   c_out,
    output logic   b_out
);
    always_comb begin
        c_out = c_in;
        b_out = b_in;
        unique case (op)
            OP_CLR_C:  c_out = 1'b0;
            OP_SET_C:  c_out = 1'b1;
            OP_CPL_C:  c_out = ~c_in;
            OP_CLR_B:  b_out = 1'b0;
            OP_SET_B:  b_out = 1'b1;
            OP_CPL_B:  b_out = ~b_in;
            OP_AND_C:  c_out = c_in & b_in;
            OP_ANDN_C: c_out = c_in & ~b_in;
            OP_OR_C:   c_out = c_in | b_in;
            OP_ORN_C:  c_out = c_in | ~b_in;
            OP_LD_C:   c_out = b_in;
            OP_ST_C:   b_out = c_in;
            default: ;
        endcase
    end
endmodule

// File: rtl/bitproc.sv
module bitproc
    import bitproc_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 8,
    parameter int RAM_BASE = 32'h20,
    localparam int POS_W   = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        op,
    input  logic [ADDR_W-1:0] bit_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              carry,
    output logic              busy,
    output logic              done
);
    typedef struct packed {
        bp_state_e         state;
        bp_op_e            op;
        logic [ADDR_W-1:0] addr;
        logic [POS_W-1:0]  pos;
        logic [DATA_W-1:0] data;
        logic              carry;
        logic              done;
    } bp_regs_t;

    bp_regs_t r_q, r_d;

    logic [ADDR_W-1:0] map_addr_d;
    logic [POS_W-1:0]  map_pos_d;
    bp_op_e            alu_op_d, in_op_d;
    logic              alu_c_d, alu_b_d;
    logic [DATA_W-1:0] merged_d;

    bitproc_addr_map #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .RAM_BASE(RAM_BASE)
    ) u_map (
        .bit_addr (bit_addr),
        .byte_addr(map_addr_d),
        .bit_pos  (map_pos_d)
    );

    assign in_op_d  = bp_op_e'(op);
    assign alu_op_d = (r_q.state == ST_IDLE) ? in_op_d : r_q.op;

    bitproc_alu u_alu (
        .op   (alu_op_d),
        .c_in (r_q.carry),
        .b_in (mem_rdata[r_q.pos]),
        .c_out(alu_c_d),
        .b_out(alu_b_d)
    );

    always_comb begin
        merged_d = mem_rdata;
        merged_d[r_q.pos] = alu_b_d;
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.op   = in_op_d;
                    r_d.addr = map_addr_d;
                    r_d.pos  = map_pos_d;
                    if (op_carry_only(in_op_d)) begin
                        r_d.carry = alu_c_d;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.state = ST_READ;
                    end
                end
            end
            ST_READ: begin
                if (op_writes_bit(r_q.op)) begin
                    r_d.data  = merged_d;
                    r_d.state = ST_WRITE;
                end else begin
                    r_d.carry = alu_c_d;
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            ST_WRITE: begin
                r_d.done  = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, op: OP_CLR_C, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr  = r_q.addr;
    assign mem_rd    = (r_q.state == ST_READ);
    assign mem_wr    = (r_q.state == ST_WRITE);
    assign mem_wdata = r_q.data;
    assign carry     = r_q.carry;
    assign busy      = (r_q.state != ST_IDLE);
    assign done      = r_q.done;

    // R10: strobes are exclusive
    a_r10_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    // R6: each write is preceded by a read of the same byte
    a_r6_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($past(mem_rd) && mem_addr == $past(mem_addr)));
    // R2: only the selected bit may differ from the byte read
    a_r2_keep_other_bits: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (((mem_wdata ^ $past(mem_rdata)) & ~(DATA_W'(1) << r_q.pos)) == '0));
    // R2: carry is untouched across a bit write
    a_r2_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $stable(carry));
    // R8: with no request and nothing in flight, carry holds
    a_r8_carry_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(start) && !$past(busy)) |-> $stable(carry));
    // R8: done comes only when the block has returned to idle
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/bitproc_tb.sv
module bitproc_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] op = '0;
    logic [7:0] bit_addr = '0;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;
    logic       mem_rd, mem_wr, carry, busy, done;

    logic [7:0] mem [256];
    logic       pre_en = 1'b0;
    logic [7:0] pre_addr = '0, pre_data = '0;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #10 clk = ~clk;

    bitproc u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .bit_addr(bit_addr),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .carry(carry), .busy(busy), .done(done)
    );

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (pre_en) mem[pre_addr] <= pre_data;
        else if (mem_wr) mem[mem_addr] <= mem_wdata;
    end

    // op, addr, carry in, initial byte, expected carry, expected byte, latency
    localparam int NV = 14;
    localparam logic [31:0] VEC [NV] = '{
        {4'd4,  8'h13, 1'b0, 8'h00, 1'b0, 8'h08, 2'd3},
        {4'd3,  8'h07, 1'b1, 8'hFF, 1'b1, 8'h7F, 2'd3},
        {4'd5,  8'h81, 1'b0, 8'hA5, 1'b0, 8'hA7, 2'd3},
        {4'd6,  8'h7F, 1'b1, 8'h80, 1'b1, 8'h80, 2'd2},
        {4'd7,  8'h7F, 1'b1, 8'h80, 1'b0, 8'h80, 2'd2},
        {4'd6,  8'h00, 1'b0, 8'h01, 1'b0, 8'h01, 2'd2},
        {4'd8,  8'hE2, 1'b0, 8'h04, 1'b1, 8'h04, 2'd2},
        {4'd9,  8'hE2, 1'b0, 8'h04, 1'b0, 8'h04, 2'd2},
        {4'd9,  8'hE2, 1'b0, 8'h00, 1'b1, 8'h00, 2'd2},
        {4'd10, 8'hD7, 1'b0, 8'h80, 1'b1, 8'h80, 2'd2},
        {4'd11, 8'h30, 1'b1, 8'h00, 1'b1, 8'h01, 2'd3},
        {4'd11, 8'hFF, 1'b0, 8'hFF, 1'b0, 8'h7F, 2'd3},
        {4'd2,  8'h00, 1'b1, 8'h5A, 1'b0, 8'h5A, 2'd1},
        {4'd14, 8'h45, 1'b1, 8'h3C, 1'b1, 8'h3C, 2'd1}
    };

    function automatic logic [7:0] byte_of(input logic [7:0] a);
        return a[7] ? (a & 8'hF8) : (8'h20 + {3'b000, a[7:3]});
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic preset(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        pre_en = 1'b1; pre_addr = a; pre_data = d;
        @(negedge clk);
        pre_en = 1'b0;
    endtask

    // issue one request, return latency in cycles (0 when done never came)
    task automatic run(input logic [3:0] o, input logic [7:0] a, output int lat);
        @(negedge clk);
        start = 1'b1; op = o; bit_addr = a;
        lat = 0;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (done) begin
                lat = i;
                break;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int lat;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 carry", carry, 0);
        check("R10 done", done, 0);
        check("R10 busy", busy, 0);
        check("R10 strobes", {mem_rd, mem_wr}, 0);
        rst_n = 1'b1;

        // R1 set and clear carry
        run(4'd1, 8'h00, lat);
        check("R1 set latency", lat, 1);
        check("R1 set carry", carry, 1);
        run(4'd0, 8'h00, lat);
        check("R1 clr carry", carry, 0);

        // table walk (R2 R3 R4 R5 R6 R7 R11)
        for (int v = 0; v < NV; v++) begin
            logic [3:0] vo;
            logic [7:0] va, vinit, vexp, ba;
            logic       vc, vec;
            int         vl;
            {vo, va, vc, vinit, vec, vexp, vl} = {VEC[v], 30'd0} >> 30;
            {vo, va, vc, vinit, vec, vexp} = VEC[v][31:2];
            vl = int'(VEC[v][1:0]);
            ba = byte_of(va);
            preset(ba, vinit);
            run(vc ? 4'd1 : 4'd0, 8'h00, lat);
            run(vo, va, lat);
            check("R7/R2-R6 latency", lat, vl);
            check("R3/R4/R5 carry", carry, vec);
            check("R7/R2/R6 byte", mem[ba], vexp);
            @(negedge clk);
            check("R8 done pulse", done, 0);
        end

        // R11 reserved code leaves carry set
        run(4'd1, 8'h00, lat);
        run(4'd13, 8'h10, lat);
        check("R11 latency", lat, 1);
        check("R11 carry", carry, 1);

        // R9 start held during a bit write is ignored
        preset(8'h22, 8'h00);
        run(4'd0, 8'h00, lat);
        @(negedge clk);
        start = 1'b1; op = 4'd4; bit_addr = 8'h16;
        @(negedge clk);
        op = 4'd2;
        check("R9 busy", busy, 1);
        @(negedge clk);
        @(negedge clk);
        check("R9 done", done, 1);
        start = 1'b0;
        check("R9 carry", carry, 0);
        check("R9 byte", mem[8'h22], 8'h40);
        @(negedge clk);
        check("R8 single done", done, 0);
        check("R9 carry after", carry, 0);

        ended = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule